// File: doc/BRIEF.md
# Key-Seeded Delay Compulsion Unit

The unit accepts a 64-bit key and a 4-bit delay count N. It returns a derived key, and it cannot return that key before N+1 clock cycles have passed after the start strobe.

A start strobe does three things:
- It captures the key and the delay.
- It loads a 64-bit Fibonacci LFSR with the key as its seed.
- It clears a cycle counter.

While the unit is busy, the LFSR takes one step per clock and the counter counts up. When the counter reaches the captured delay, the unit registers the current LFSR state XORed with the captured key on the output. It raises a one-cycle done pulse in the same cycle.

The result is the LFSR state after exactly N serial steps. A shortcut of the kind a single-cycle rotation allows would give a different value, so the waiting time is built into the value itself. The unit is meant to sit beside a cipher datapath. A key scheduler asks it for a round key and must wait the key-dependent number of cycles.

Top module: `dcu_top`

## Requirements
- R1: While reset is asserted, and at the first cycle after release, key_o is all zeros and done_o is low.
- R2: start_i accepted while idle captures key_i and delay_i. Changes to key_i or delay_i after that edge do not alter the result of the operation in progress.
- R3: An all-zero key is seeded into the LFSR as the constant 64'h1, so the LFSR state is never zero.
- R4: The LFSR steps as next = {s[62:0], s[63]^s[62]^s[60]^s[59]}, where bit 0 is the LSB.
- R5: If start is accepted at clock edge E0, done_o first goes high after edge E0+N+1, where N is the captured delay (0..15). It is never high earlier.
- R6: The value on key_o when done_o is high equals the LFSR seed advanced N steps, XORed with the captured key.
- R7: With delay 0, done_o rises one cycle after start. The output is all zeros for any nonzero key.
- R8: done_o is high for exactly one cycle. key_o keeps its value until the next operation completes.
- R9: start_i asserted while an operation is in progress is ignored. It changes neither the result nor the completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; sampled only when idle |
| key_i | input | 64 | Key and LFSR seed |
| delay_i | input | 4 | Requested delay N in cycles |
| key_o | output | 64 | Derived key, held between completions |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default parameters: a 64-bit key, a 4-bit delay and the 64,63,61,60 tap set. A 4-bit delay keeps the delay space small, so every value from 0 to 15 is exercised. For each delay the bench checks that done stays low on every cycle before the expected one. The derived key is compared against an LFSR model written from R4 in the bench. The all-zero-seed substitution is covered by a zero key, and capture isolation by disturbing key_i, delay_i and start_i during a run.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dcu_state_e;
endpackage

// File: rtl/dcu_lfsr.sv
module dcu_lfsr #(
  parameter int             W         = 64,
  parameter logic [W-1:0]   TAPS      = 64'hD800_0000_0000_0000,
  parameter logic [W-1:0]   ZERO_SEED = 64'h1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st_q;
  logic         fb;

  assign fb = ^(st_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= ZERO_SEED;
    else if (load_i) st_q <= (seed_i == '0) ? ZERO_SEED : seed_i;
    else if (step_i) st_q <= {st_q[W-2:0], fb};
  end

  assign state_o = st_q;

  assert_never_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);
  assert_step_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> st_q[W-1:1] == $past(st_q[W-2:0]));
endmodule

// File: rtl/dcu_counter.sv
module dcu_counter #(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [DW-1:0] limit_i,
  output logic          match_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign match_o = (cnt_q == limit_i);

  assert_count_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |-> cnt_q < limit_i);
endmodule

// File: rtl/dcu_ctrl.sv
module dcu_ctrl
  import dcu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic match_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o
);
  dcu_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_RUN;
      ST_RUN:  if (match_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign busy_o = (st_q == ST_RUN);
  assign load_o = !busy_o && start_i;
  assign step_o = busy_o && !match_i;
  assign fin_o  = busy_o && match_i;

  assert_one_action_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_o, step_o, fin_o}));
endmodule

// File: rtl/dcu_top.sv
module dcu_top #(
  parameter int                  KEY_W     = 64,
  parameter int                  DLY_W     = 4,
  parameter logic [KEY_W-1:0]    TAP_MASK  = 64'hD800_0000_0000_0000,
  parameter logic [KEY_W-1:0]    ZERO_SEED = 64'h1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic [KEY_W-1:0] key_o,
  output logic             done_o
);
  logic [KEY_W-1:0] key_q, lfsr_st, out_q;
  logic [DLY_W-1:0] dly_q;
  logic             load, step, fin, busy, match, done_q;

  dcu_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .match_i(match),
    .load_o(load), .step_o(step), .fin_o(fin), .busy_o(busy)
  );

  dcu_counter #(.DW(DLY_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(load), .inc_i(step), .limit_i(dly_q), .match_o(match)
  );

  dcu_lfsr #(.W(KEY_W), .TAPS(TAP_MASK), .ZERO_SEED(ZERO_SEED)) u_lfsr (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .seed_i(key_i), .state_o(lfsr_st)
  );

  // capture on accepted start only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      dly_q <= '0;
    end else if (load) begin
      key_q <= key_i;
      dly_q <= delay_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) out_q <= lfsr_st ^ key_q;
    end
  end

  assign key_o  = out_q;
  assign done_o = done_q;

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_key_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(key_o));
  assert_busy_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> ($stable(key_q) && $stable(dly_q)));
  assert_done_after_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy));
endmodule

// File: tb/dcu_top_tb_top.sv
module dcu_top_tb_top;
  localparam time CLK_P = 20ns;
  localparam logic [63:0] TAPS = 64'hD800_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] key = '0;
  logic [3:0]  dly = '0;
  logic [63:0] key_out;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  dcu_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .key_i(key),
    .delay_i(dly), .key_o(key_out), .done_o(done)
  );

  function automatic logic [63:0] model(input logic [63:0] k, input int n);
    logic [63:0] s;
    s = (k == '0) ? 64'h1 : k;
    for (int i = 0; i < n; i++) s = {s[62:0], ^(s & TAPS)};
    return s ^ k;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // mode 0 plain, 1 start pulses while busy, 2 inputs change while busy
  task automatic run_op(input logic [63:0] k, input int n, input int mode, input string req);
    logic [63:0] exp;
    exp = model(k, n);
    @(negedge clk);
    key = k; dly = 4'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i <= n; i++) begin
      if (i < n && mode == 1) begin start = 1'b1; key = ~k; dly = 4'(n + 3); end
      if (i < n && mode == 2) begin key = k ^ 64'(i + 1); dly = 4'(15 - n); end
      if (i == n) start = 1'b0;
      @(negedge clk);
      if (i < n) check({req, " R5 early done"}, 64'(done), 64'd0);
    end
    check({req, " R5 done on time"}, 64'(done), 64'd1);
    check({req, " R6 key value"}, key_out, exp);
    @(negedge clk);
    check({req, " R8 done pulse"}, 64'(done), 64'd0);
    check({req, " R8 key hold"}, key_out, exp);
  endtask

  task automatic t_reset;
    check("R1 reset done", 64'(done), 64'd0);
    check("R1 reset key", key_out, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release done", 64'(done), 64'd0);
    check("R1 after release key", key_out, 64'd0);
  endtask

  task automatic t_zero_delay;
    run_op(64'hA5A5_0F0F_1234_5678, 0, 0, "R7 zero delay");
    check("R7 zero output", key_out, 64'd0);
  endtask

  task automatic t_all_delays;
    for (int n = 0; n < 16; n++)
      run_op(64'h0123_4567_89AB_CDEF ^ (64'(n) << 17) ^ 64'(n * 7919), n, 0, "R4 R6 sweep");
  endtask

  task automatic t_zero_key;
    run_op(64'd0, 0, 0, "R3 zero key n0");
    check("R3 substitute seed", key_out, 64'h1);
    run_op(64'd0, 9, 0, "R3 zero key n9");
  endtask

  task automatic t_busy_start;
    run_op(64'hDEAD_BEEF_CAFE_F00D, 6, 1, "R9 busy start");
    run_op(64'h8000_0000_0000_0001, 1, 1, "R9 busy start short");
  endtask

  task automatic t_input_change;
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 11, 2, "R2 inputs change");
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_zero_delay();
    t_all_delays();
    t_zero_key();
    t_busy_start();
    t_input_change();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule